// File: doc/BRIEF.md
# Compare-Match Timer Counter Channel

One 16-bit timer/counter channel, driven from a register port. Each count tick comes from a source that a select input picks. The source is either one of several prescaled enable strobes or the rising edges of an external clock input. The counter can run freely and wrap. It can also count up to a top compare value (compare C) and restart from zero. An optional stop bit halts counting at that match, which gives a oneshot.

Two compare registers drive a waveform output. A match on compare A sets the output and a match on compare C clears it. The waveform of one channel can serve as the external clock of the next channel, so two channels cascade into a wider free-running count.

A status register latches the compare and wrap events and is cleared by reading it. Set and clear mask registers choose which events drive the interrupt line. A global sync input zeroes the counter, so several channels can restart together.

Top module: `cmt_channel`

## Requirements
- R1: In free-run mode (MODE bit0 = 0) each tick raises the count by one. A tick at 0xFFFF wraps the count to 0 and sets the wrap flag, STAT bit2.
- R2: In restart mode (MODE bit0 = 1) a tick that arrives with the count equal to compare C loads 0 and sets the C flag, STAT bit0. One cycle of the count therefore takes C+1 ticks.
- R3: With MODE bit1 = 1, a tick that matches compare C clears the run state, and the count then holds. CTRL reads back the run state in bit0.
- R4: A CTRL write with bit0 (enable) and bit2 (trigger) both set zeroes the count and starts counting in the same cycle.
- R5: A CTRL write with bit1 (disable) stops counting, and it wins over bit0 in the same write. While stopped, ticks leave the count unchanged.
- R6: The waveform output goes high on a tick at count == compare A and low on a tick at count == compare C. Compare C wins when both match. A tick at compare A also sets STAT bit1.
- R7: Inputs src_sel 0 to 3 pick pre_tick[src_sel] as the tick. A src_sel of 4 counts rising edges of ext_clk after a two-stage synchroniser. Any other value gives no ticks.
- R8: Writing a one to a bit of IEN (address 4) sets that mask bit, and writing a one to a bit of IDIS (address 5) clears it. Both addresses read back the 3-bit mask. Writing 0xFF to IDIS masks every source.
- R9: irq is high whenever a STAT flag with its mask bit set is high. A STAT read (address 6) returns the flags and clears them, but an event in the same cycle stays latched.
- R10: A one-cycle pulse on sync_in zeroes the count and leaves the run state unchanged.
- R11: In restart mode with compare C = 0 the count stays 0 and every tick sets the C flag.
- R12: After reset the count, the run state, MODE, both compares, the mask, the flags, wave_out and irq are all 0. Register map: 0 MODE, 1 CMPA, 2 CMPC, 3 CTRL, 4 IEN, 5 IDIS, 6 STAT, 7 count. Read data appears one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Count source select |
| pre_tick | input | 4 | Prescaled tick strobes, one cycle each |
| ext_clk | input | 1 | External clock for chaining, asynchronous |
| sync_in | input | 1 | Global counter reset strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| wave_out | output | 1 | Compare-driven waveform |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs the counter through a full 65536-tick wrap. A design that compares against the wrong value, or that flags overflow from the restart path, shows the wrong STAT or count there. Restart mode is checked for its exact C+1 period and for compare C = 0. An off-by-one compare, or a counter that escapes past zero, gives a wrong count. The oneshot test checks that counting stops on the matching tick and not one tick later. The disable-over-enable write and the tick that coincides with a STAT read are also exercised; a design that gets either wrong keeps running, or loses an interrupt event. The bench also checks that compare C wins over compare A on wave_out, and that ext_clk edges are counted once each.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_FLAGS = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE = 3'd0,
        RA_CMPA = 3'd1,
        RA_CMPC = 3'd2,
        RA_CTRL = 3'd3,
        RA_IEN  = 3'd4,
        RA_IDIS = 3'd5,
        RA_STAT = 3'd6,
        RA_CNT  = 3'd7
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DIS_BIT  = 1;
    localparam int CTRL_TRIG_BIT = 2;

    // mode register: bit1 stop on compare C, bit0 restart at compare C
    typedef struct packed {
        logic stop_on_c;
        logic auto_rst;
    } mode_t;

    // single-cycle commands decoded from a CTRL write
    typedef struct packed {
        logic start;
        logic halt;
        logic trig;
    } ctrl_cmd_t;

    // event vector, bit positions equal the STAT flag positions
    typedef struct packed {
        logic ovf;
        logic a_hit;
        logic c_hit;
    } evt_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic wr, input logic [2:0] bits);
        ctrl_cmd_t c;
        c.start = wr & bits[CTRL_EN_BIT];
        c.halt  = wr & bits[CTRL_DIS_BIT];
        c.trig  = wr & bits[CTRL_TRIG_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cmt_tick_sel.sv
module cmt_tick_sel #(
    parameter int NUM_PRE = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_PRE-1:0] pre_tick,
    input  logic               ext_clk,
    output logic               tick
);
    localparam int NUM_SRC = NUM_PRE + 1;

    // [0] first sync stage, [1] second sync stage, [2] previous level
    logic [2:0]         ext_sh;
    logic               ext_edge;
    logic [NUM_SRC-1:0] srcs;
    logic [NUM_SRC-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) ext_sh <= '0;
        else     ext_sh <= {ext_sh[1:0], ext_clk};
    end

    assign ext_edge = ext_sh[1] & ~ext_sh[2];
    assign srcs     = {ext_edge, pre_tick};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = (src_sel == SEL_W'(g)) & srcs[g];
    end

    assign tick = |hit;

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpc,
    input  ctrl_cmd_t        cmd,
    input  logic             sync_rst,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             wave,
    output evt_t             evt
);
    logic adv;
    logic a_eq;
    logic c_eq;
    logic at_top;

    assign adv    = running & tick;
    assign a_eq   = (cnt == cmpa);
    assign c_eq   = (cnt == cmpc);
    assign at_top = &cnt;

    always_comb begin
        evt.c_hit = adv & c_eq;
        evt.a_hit = adv & a_eq;
        evt.ovf   = adv & at_top & ~(mode.auto_rst & c_eq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.trig || sync_rst) begin
            cnt <= '0;
        end else if (adv) begin
            if (mode.auto_rst && c_eq) cnt <= '0;
            else                       cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               running <= 1'b0;
        else if (cmd.halt)                     running <= 1'b0;
        else if (cmd.start)                    running <= 1'b1;
        else if (evt.c_hit && mode.stop_on_c)  running <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            wave <= 1'b0;
        else if (evt.c_hit) wave <= 1'b0;
        else if (evt.a_hit) wave <= 1'b1;
    end

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CNT_W-1:0]     wdata,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 running,
    input  evt_t                 evt,
    output mode_t                mode,
    output logic [CNT_W-1:0]     cmpa,
    output logic [CNT_W-1:0]     cmpc,
    output ctrl_cmd_t            cmd,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] mask,
    output logic [CNT_W-1:0]     rdata
);
    reg_addr_e ra;
    logic      wr_ctrl;
    logic      rd_stat;

    assign ra      = reg_addr_e'(addr);
    assign wr_ctrl = wr_en && (ra == RA_CTRL);
    assign rd_stat = rd_en && (ra == RA_STAT);
    assign cmd     = decode_ctrl(wr_ctrl, wdata[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            cmpa <= '0;
            cmpc <= '0;
            mask <= '0;
        end else if (wr_en) begin
            case (ra)
                RA_MODE: mode <= mode_t'(wdata[1:0]);
                RA_CMPA: cmpa <= wdata;
                RA_CMPC: cmpc <= wdata;
                RA_IEN:  mask <= mask | wdata[NUM_FLAGS-1:0];
                RA_IDIS: mask <= mask & ~wdata[NUM_FLAGS-1:0];
                default: ;
            endcase
        end
    end

    // a new event in the cycle of a clearing read stays latched
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (rd_stat ? '0 : flags) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (ra)
                RA_MODE:          rdata <= CNT_W'(mode);
                RA_CMPA:          rdata <= cmpa;
                RA_CMPC:          rdata <= cmpc;
                RA_CTRL:          rdata <= CNT_W'(running);
                RA_IEN, RA_IDIS:  rdata <= CNT_W'(mask);
                RA_STAT:          rdata <= CNT_W'(flags);
                default:          rdata <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_PRE = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_PRE-1:0] pre_tick,
    input  logic               ext_clk,
    input  logic               sync_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic               wave_out,
    output logic               irq
);
    logic                 tick;
    mode_t                mode_q;
    logic [CNT_W-1:0]     cmpa_q;
    logic [CNT_W-1:0]     cmpc_q;
    ctrl_cmd_t            cmd;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] mask_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 running;
    evt_t                 evt;

    cmt_tick_sel #(.NUM_PRE(NUM_PRE), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst(rst), .src_sel(src_sel), .pre_tick(pre_tick),
        .ext_clk(ext_clk), .tick(tick)
    );

    cmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cnt(cnt_q), .running(running), .evt(evt),
        .mode(mode_q), .cmpa(cmpa_q), .cmpc(cmpc_q), .cmd(cmd),
        .flags(flags_q), .mask(mask_q), .rdata(rdata)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode_q), .cmpa(cmpa_q),
        .cmpc(cmpc_q), .cmd(cmd), .sync_rst(sync_in), .cnt(cnt_q),
        .running(running), .wave(wave_out), .evt(evt)
    );

    assign irq = |(flags_q & mask_q);

endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick,
    input mode_t                mode,
    input logic [CNT_W-1:0]     cmpc,
    input logic [CNT_W-1:0]     cnt,
    input logic                 running,
    input ctrl_cmd_t            cmd,
    input logic                 sync_in,
    input logic [NUM_FLAGS-1:0] mask,
    input logic                 irq,
    input logic                 wave
);
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && tick && !mode.auto_rst && !cmd.trig && !sync_in)
        |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

    AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (running && tick && mode.auto_rst && cnt == cmpc) |=> cnt == '0); // R2

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (running && tick && mode.stop_on_c && cnt == cmpc && !cmd.start)
        |=> !running); // R3

    AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmd.trig |=> cnt == '0); // R4

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> !running); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd.trig && !sync_in) |=> $stable(cnt)); // R5

    AST_WAVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (running && tick && cnt == cmpc) |=> !wave); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R8

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> cnt == '0); // R10

endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q), .cmpc(cmpc_q),
    .cnt(cnt_q), .running(running), .cmd(cmd), .sync_in(sync_in),
    .mask(mask_q), .irq(irq), .wave(wave_out)
);

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_sel = 3'd0;
    logic [3:0]  pre_tick = 4'd0;
    logic        ext_clk = 1'b0;
    logic        sync_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        wave_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cmt_channel u_cmt_channel (
        .clk(clk), .rst(rst), .src_sel(src_sel), .pre_tick(pre_tick),
        .ext_clk(ext_clk), .sync_in(sync_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wave_out(wave_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic run(input int idx, input int n);
        @(negedge clk);
        pre_tick[idx] = 1'b1;
        repeat (n) @(negedge clk);
        pre_tick[idx] = 1'b0;
    endtask

    task automatic restart(input logic [15:0] m);
        wr(3, 16'h2);
        wr(0, m);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(7, v); chk("R12 count", v, 0);
        rd(6, v); chk("R12 stat", v, 0);
        rd(0, v); chk("R12 mode", v, 0);
        rd(4, v); chk("R12 mask", v, 0);
        rd(3, v); chk("R12 run", v, 0);
        rd(2, v); chk("R12 cmpc", v, 0);
        chk("R12 wave", wave_out, 0);
        chk("R12 irq", irq, 0);
    endtask

    task automatic t_free();
        logic [15:0] v;
        restart(16'h0);
        wr(3, 16'h5);
        run(0, 5);
        rd(7, v); chk("R1 count 5", v, 5);
        rd(6, v);
        run(0, 65531);
        rd(7, v); chk("R1 wrap count", v, 0);
        rd(6, v); chk("R1 wrap flag", v, 16'h4);
        rd(6, v); chk("R9 read clears", v, 0);
    endtask

    task automatic t_auto();
        logic [15:0] v;
        restart(16'h1);
        wr(1, 16'd1);
        wr(2, 16'd3);
        rd(6, v);
        wr(3, 16'h5);
        run(0, 2);
        rd(7, v); chk("R4 count after trig", v, 2);
        chk("R6 wave set at A", wave_out, 1);
        run(0, 1);
        chk("R6 wave held", wave_out, 1);
        run(0, 1);
        rd(7, v); chk("R2 restart to 0", v, 0);
        chk("R6 wave clear at C", wave_out, 0);
        rd(6, v); chk("R2 C and A flags", v, 16'h3);
        run(0, 4);
        rd(7, v); chk("R2 period C+1", v, 0);
        run(0, 2);
        chk("R6 wave set again", wave_out, 1);
        wr(1, 16'd3);
        run(0, 2);
        chk("R6 C wins over A", wave_out, 0);
    endtask

    task automatic t_oneshot();
        logic [15:0] v;
        restart(16'h3);
        wr(1, 16'hFFFF);
        wr(2, 16'd4);
        rd(6, v);
        wr(3, 16'h5);
        run(0, 10);
        rd(7, v); chk("R3 held after stop", v, 0);
        rd(3, v); chk("R3 run cleared", v, 0);
        rd(6, v); chk("R3 C flag", v & 16'h1, 1);
        wr(3, 16'h5);
        run(0, 2);
        rd(7, v); chk("R4 restart count", v, 2);
        rd(3, v); chk("R4 running", v, 1);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        restart(16'h0);
        wr(3, 16'h5);
        run(0, 3);
        wr(3, 16'h2);
        run(0, 5);
        rd(7, v); chk("R5 stop holds", v, 3);
        wr(3, 16'h3);
        run(0, 2);
        rd(7, v); chk("R5 disable wins", v, 3);
        wr(3, 16'h1);
        run(0, 2);
        rd(7, v); chk("R5 enable resumes", v, 5);
    endtask

    task automatic t_czero();
        logic [15:0] v;
        restart(16'h1);
        wr(2, 16'd0);
        wr(3, 16'h5);
        rd(6, v);
        run(0, 3);
        rd(7, v); chk("R11 count stays 0", v, 0);
        rd(6, v); chk("R11 flag", v, 1);
        rd(6, v); chk("R11 cleared", v, 0);
        run(0, 1);
        rd(6, v); chk("R11 flag each tick", v, 1);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(5, 16'hFF);
        rd(4, v); chk("R8 all masked", v, 0);
        rd(6, v);
        wr(4, 16'hFF);
        rd(4, v); chk("R8 set mask", v, 7);
        wr(5, 16'h6);
        rd(5, v); chk("R8 clear mask", v, 1);
        chk("R9 irq idle", irq, 0);
        run(0, 1);
        chk("R9 irq raised", irq, 1);
        rd(6, v);
        chk("R9 irq after read", irq, 0);
        @(negedge clk);
        pre_tick[0] = 1'b1; rd_en = 1'b1; addr = 3'd6;
        @(negedge clk);
        pre_tick[0] = 1'b0; rd_en = 1'b0;
        rd(6, v); chk("R9 event kept on read", v, 1);
        wr(5, 16'hFF);
        run(0, 1);
        chk("R8 masked no irq", irq, 0);
    endtask

    task automatic t_sync();
        logic [15:0] v;
        restart(16'h0);
        wr(3, 16'h5);
        run(0, 7);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        rd(7, v); chk("R10 sync zero", v, 0);
        rd(3, v); chk("R10 still running", v, 1);
        run(0, 2);
        rd(7, v); chk("R10 counts on", v, 2);
    endtask

    task automatic t_src();
        logic [15:0] v;
        src_sel = 3'd1;
        run(0, 5);
        rd(7, v); chk("R7 unselected ignored", v, 2);
        run(1, 3);
        rd(7, v); chk("R7 source 1", v, 5);
        src_sel = 3'd7;
        @(negedge clk); pre_tick = 4'hF;
        repeat (4) @(negedge clk);
        pre_tick = 4'h0;
        rd(7, v); chk("R7 no source", v, 5);
        src_sel = 3'd4;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(7, v); chk("R7 ext edges", v, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_free();
        t_auto();
        t_oneshot();
        t_disable();
        t_czero();
        t_irq();
        t_sync();
        t_src();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule